// File: doc/BRIEF.md
# Programmable-timing static memory controller

The controller connects a 32-bit on-chip request port to an external asynchronous static memory bus. Four banks share that bus: the address, the data and the strobes. Two bank-select bits in the request address pick the bank, and that bank gets its own active-low chip select. Only one external access runs at a time. Each bank is configured separately in three ways. It has a data width of 8 or 16 bits. It has a read timing set and a separate write timing set. Each set holds an address-setup delay, a count of wait states and a count of bus turnaround cycles, and every field is 4 bits.

A 32-bit request becomes consecutive narrow accesses: two for a 16-bit bank and four for an 8-bit bank. The external address steps by one for each of them. A read returns the assembled word in a single pulse on `rd_valid_o`. Writes are posted into a two-entry buffer that holds only data and byte strobes. The buffer holds one burst at a time. The burst address is kept once, and each following beat goes to the next word. The internal side is released while the slow external writes are still running.

Top module: `stmem_ctrl`

## Requirements
- R1: When no access is in progress, `mem_cs_no` is all ones. During an access, exactly one bit is low: bit b, where b is `req_addr_i[27:26]` of the request. `mem_oe_no` and `mem_we_no` go low only while a chip select is low.
- R2: Each narrow access starts with a setup phase. In that phase the chip select is low, the address is driven and no strobe is active. It lasts delay+1 cycles. The delay field is bits [3:0] of the bank's timing field.
- R3: `mem_oe_no` stays low for wait+1 cycles on a read. `mem_we_no` stays low for wait+1 cycles on a write. The wait field is bits [7:4] of the timing field. The address does not change during a strobe, and the two strobes are never low together.
- R4: A read uses bank b's field `rd_tim_i[12b+11:12b]`. A write uses `wr_tim_i[12b+11:12b]`. The two sets are applied independently.
- R5: After the last narrow access of a word, every chip select stays high for turn+1 cycles before the next access starts. The turn field is bits [11:8] of the timing set of the operation that just finished. The extra cycle is arbitration.
- R6: On a 16-bit bank (`cfg_w16_i[b]`=1), a word at byte offset A uses external addresses A/2 and A/2+1. Halfword k carries data bits [16k+15:16k]. On an 8-bit bank, a word uses A to A+3, and byte k travels on lane 0 carrying bits [8k+7:8k].
- R7: On a write, `mem_be_no` is the inverse of the strobes for the lanes of the current access. For 16-bit banks the lanes are strobe bits {2k+1,2k}. For 8-bit banks the lanes are {1, strobe bit k}, with bit 1 held high. An access with no strobed lane gives no write pulse. Reads drive `mem_be_no`=00. `mem_dq_oe_o` is high throughout every write access.
- R8: A write is accepted while the buffer has room. Acceptance does not wait for the external write.
- R9: A write with `req_burst_i`=1 that arrives while the buffer holds earlier beats goes to the previous beat's address+4. Its `req_addr_i` is ignored.
- R10: `req_ready_o` is low in three cases. The first is a read or a non-continuation write while the buffer is not empty. The second is a continuation while the buffer holds two entries. The third is any request while a read is outstanding.
- R11: A read is answered by a single-cycle `rd_valid_o` pulse. The assembled word appears on `rd_data_o` in the same cycle.
- R12: During reset, all chip selects, `mem_oe_no` and `mem_we_no` are high, `rd_valid_o` is low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| req_valid_i | input | 1 | request valid |
| req_ready_o | output | 1 | request accepted on valid and ready |
| req_write_i | input | 1 | 1 write, 0 read |
| req_burst_i | input | 1 | write continues the current burst |
| req_addr_i | input | 32 | byte address; bits [27:26] bank |
| req_wdata_i | input | 32 | write data |
| req_strb_i | input | 4 | write byte strobes |
| rd_valid_o | output | 1 | read data pulse |
| rd_data_o | output | 32 | read data |
| cfg_w16_i | input | 4 | per-bank width, 1 = 16 bit |
| rd_tim_i | input | 48 | per-bank read timing {turn,wait,delay} |
| wr_tim_i | input | 48 | per-bank write timing {turn,wait,delay} |
| mem_cs_no | output | 4 | bank chip selects, active low |
| mem_oe_no | output | 1 | output enable, active low |
| mem_we_no | output | 1 | write enable, active low |
| mem_be_no | output | 2 | byte lane selects, active low |
| mem_addr_o | output | 20 | external address |
| mem_dq_o | output | 16 | write data to memory |
| mem_dq_oe_o | output | 1 | data bus drive enable |
| mem_dq_i | input | 16 | read data from memory |

## Verification
The hardest state to reach is a full write buffer, with a word already running externally, while further requests arrive. In that state a third continuation beat and a following read must both be held off, and the read must then see the drained data. The stimulus gets there with a three-beat burst sent to a bank with slow write timing. The second beat carries a bogus address. The bench records when each beat and the read are accepted, relative to the first write pulse, and measures the chip-select gaps between words. It then reads back a drained word.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_TURN} seq_st_e;
  typedef struct packed {
    logic [3:0] turn;
    logic [3:0] wait_c;
    logic [3:0] dly;
  } tim_t;
  localparam int unsigned TIM_W = 12;
endpackage

// File: rtl/smc_wbuf.sv
module smc_wbuf #(
  parameter int unsigned DW    = 36,
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [PW:0]   cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (PW+1)'(DEPTH));
  assign dout_o  = mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= (wptr_q == PW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      if (pop_i)  rptr_q <= (rptr_q == PW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
      cnt_q <= cnt_q + (PW+1)'(push_i) - (PW+1)'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= din_i;
  end
endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
#(
  parameter int unsigned NB     = 4,
  parameter int unsigned EXT_AW = 20,
  localparam int unsigned BW    = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic              wide_i,
  input  logic [BW-1:0]     bank_i,
  input  logic [EXT_AW-1:0] ext_addr_i,
  input  tim_t              tim_i,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        strb_i,
  input  logic [15:0]       dq_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_valid_o,
  output logic [31:0]       rd_data_o,
  output logic [NB-1:0]     cs_no,
  output logic              oe_no,
  output logic              we_no,
  output logic [1:0]        be_no,
  output logic [EXT_AW-1:0] addr_o,
  output logic [15:0]       dq_o,
  output logic              dq_oe_o
);
  seq_st_e           st_q;
  logic              wr_q, wide_q;
  logic [BW-1:0]     bank_q;
  logic [EXT_AW-1:0] base_q;
  tim_t              tim_q;
  logic [31:0]       wdata_q, rdata_q;
  logic [3:0]        strb_q;
  logic [1:0]        sub_q;
  logic [3:0]        cnt_q;
  logic              rvld_q;

  logic [1:0] last_sub, lanes;
  logic       active, strobe_end, last;

  assign last_sub   = wide_q ? 2'd1 : 2'd3;
  assign last       = (sub_q == last_sub);
  assign active     = (st_q == ST_SETUP) || (st_q == ST_STROBE);
  assign strobe_end = (st_q == ST_STROBE) && (cnt_q == '0);
  assign lanes      = wide_q ? strb_q[{sub_q, 1'b0} +: 2] : {1'b0, strb_q[sub_q]};

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = strobe_end && last;
  assign rd_valid_o = rvld_q;
  assign rd_data_o  = rdata_q;
  assign cs_no      = active ? ~(NB'(1) << bank_q) : '1;
  assign oe_no      = !((st_q == ST_STROBE) && !wr_q);
  assign we_no      = !((st_q == ST_STROBE) && wr_q && (|lanes));
  assign be_no      = !active ? 2'b11 :
                      !wr_q   ? 2'b00 :
                      wide_q  ? ~lanes : {1'b1, ~lanes[0]};
  assign addr_o     = base_q + EXT_AW'(sub_q);
  assign dq_o       = wide_q ? wdata_q[{sub_q, 4'b0} +: 16] : {8'h00, wdata_q[{sub_q, 3'b0} +: 8]};
  assign dq_oe_o    = active && wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      bank_q  <= '0;
      base_q  <= '0;
      tim_q   <= '0;
      wdata_q <= '0;
      strb_q  <= '0;
      sub_q   <= '0;
      cnt_q   <= '0;
      rdata_q <= '0;
      rvld_q  <= 1'b0;
    end else begin
      rvld_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          wr_q    <= wr_i;
          wide_q  <= wide_i;
          bank_q  <= bank_i;
          base_q  <= ext_addr_i;
          tim_q   <= tim_i;
          wdata_q <= wdata_i;
          strb_q  <= strb_i;
          sub_q   <= '0;
          cnt_q   <= tim_i.dly;
          st_q    <= ST_SETUP;
        end
        ST_SETUP: begin
          if (cnt_q == '0) begin
            st_q  <= ST_STROBE;
            cnt_q <= tim_q.wait_c;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_STROBE: begin
          if (cnt_q == '0) begin
            if (!wr_q) begin
              if (wide_q) rdata_q[{sub_q, 4'b0} +: 16] <= dq_i;
              else        rdata_q[{sub_q, 3'b0} +: 8]  <= dq_i[7:0];
            end
            if (last) begin
              rvld_q <= !wr_q;
              if (tim_q.turn == '0) st_q <= ST_IDLE;
              else begin
                st_q  <= ST_TURN;
                cnt_q <= tim_q.turn - 1'b1;
              end
            end else begin
              sub_q <= sub_q + 1'b1;
              cnt_q <= tim_q.dly;
              st_q  <= ST_SETUP;
            end
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_TURN: begin
          if (cnt_q == '0) st_q <= ST_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stmem_ctrl.sv
module stmem_ctrl
  import smc_pkg::*;
#(
  parameter int unsigned NB       = 4,
  parameter int unsigned EXT_AW   = 20,
  parameter int unsigned BANK_LSB = 26,
  parameter int unsigned WB_DEPTH = 2,
  localparam int unsigned BW      = $clog2(NB),
  localparam int unsigned TW      = TIM_W * NB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_burst_i,
  input  logic [31:0]       req_addr_i,
  input  logic [31:0]       req_wdata_i,
  input  logic [3:0]        req_strb_i,
  output logic              rd_valid_o,
  output logic [31:0]       rd_data_o,
  input  logic [NB-1:0]     cfg_w16_i,
  input  logic [TW-1:0]     rd_tim_i,
  input  logic [TW-1:0]     wr_tim_i,
  output logic [NB-1:0]     mem_cs_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [1:0]        mem_be_no,
  output logic [EXT_AW-1:0] mem_addr_o,
  output logic [15:0]       mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [15:0]       mem_dq_i
);
  tim_t rd_tab [NB];
  tim_t wr_tab [NB];
  for (genvar b = 0; b < NB; b++) begin : g_tab
    assign rd_tab[b] = rd_tim_i[b*TIM_W +: TIM_W];
    assign wr_tab[b] = wr_tim_i[b*TIM_W +: TIM_W];
  end

  logic        rd_pend_q;
  logic [31:0] rd_addr_q, next_addr_q;
  logic        buf_empty, buf_full, push, pop, accept, new_ok, cont_ok;
  logic [35:0] buf_head;
  logic        busy, done, start, op_wr, wide;
  logic [31:0] op_addr;
  logic [BW-1:0]     bank;
  logic [EXT_AW-1:0] ext_addr;
  logic        unused_addr;

  assign new_ok      = buf_empty && !rd_pend_q;
  assign cont_ok     = req_write_i && req_burst_i && !buf_empty && !buf_full && !rd_pend_q;
  assign req_ready_o = new_ok || cont_ok;
  assign accept      = req_valid_i && req_ready_o;
  assign push        = accept && req_write_i;

  assign op_wr    = !rd_pend_q;
  assign op_addr  = rd_pend_q ? rd_addr_q : next_addr_q;
  assign bank     = op_addr[BANK_LSB +: BW];
  assign wide     = cfg_w16_i[bank];
  assign ext_addr = wide ? op_addr[EXT_AW:1] : op_addr[EXT_AW-1:0];
  assign start    = !busy && (rd_pend_q || !buf_empty);
  assign pop      = done && op_wr;
  assign unused_addr = ^{op_addr[31:BANK_LSB+BW], op_addr[BANK_LSB-1:EXT_AW+1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q   <= 1'b0;
      rd_addr_q   <= '0;
      next_addr_q <= '0;
    end else begin
      if (accept && !req_write_i) begin
        rd_pend_q <= 1'b1;
        rd_addr_q <= req_addr_i;
      end else if (done && rd_pend_q) begin
        rd_pend_q <= 1'b0;
      end
      // burst base taken only when the buffer is empty; later beats follow on
      if (push && buf_empty) next_addr_q <= req_addr_i;
      else if (pop)          next_addr_q <= next_addr_q + 32'd4;
    end
  end

  smc_wbuf #(.DW(36), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .din_i   ({req_strb_i, req_wdata_i}),
    .pop_i   (pop),
    .dout_o  (buf_head),
    .empty_o (buf_empty),
    .full_o  (buf_full)
  );

  smc_seq #(.NB(NB), .EXT_AW(EXT_AW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .wr_i       (op_wr),
    .wide_i     (wide),
    .bank_i     (bank),
    .ext_addr_i (ext_addr),
    .tim_i      (op_wr ? wr_tab[bank] : rd_tab[bank]),
    .wdata_i    (buf_head[31:0]),
    .strb_i     (buf_head[35:32]),
    .dq_i       (mem_dq_i),
    .busy_o     (busy),
    .done_o     (done),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .cs_no      (mem_cs_no),
    .oe_no      (mem_oe_no),
    .we_no      (mem_we_no),
    .be_no      (mem_be_no),
    .addr_o     (mem_addr_o),
    .dq_o       (mem_dq_o),
    .dq_oe_o    (mem_dq_oe_o)
  );
endmodule

// File: rtl/smc_chk.sv
module smc_chk #(
  parameter int unsigned NB     = 4,
  parameter int unsigned EXT_AW = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_valid_o,
  input logic [NB-1:0]     mem_cs_no,
  input logic              mem_oe_no,
  input logic              mem_we_no,
  input logic [1:0]        mem_be_no,
  input logic [EXT_AW-1:0] mem_addr_o,
  input logic              mem_dq_oe_o
);
  logic strobe;
  assign strobe = !mem_oe_no || !mem_we_no;

  assert_cs_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_cs_no));
  assert_strobe_has_cs_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |-> (mem_cs_no != '1));
  assert_oe_we_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no));
  assert_addr_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && $past(strobe)) |-> $stable(mem_addr_o));
  assert_we_lane_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (mem_be_no != 2'b11 && mem_dq_oe_o));
  assert_oe_no_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (!mem_dq_oe_o && mem_be_no == 2'b00));
  assert_rdv_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
endmodule

bind stmem_ctrl smc_chk #(.NB(NB), .EXT_AW(EXT_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_valid_o  (rd_valid_o),
  .mem_cs_no   (mem_cs_no),
  .mem_oe_no   (mem_oe_no),
  .mem_we_no   (mem_we_no),
  .mem_be_no   (mem_be_no),
  .mem_addr_o  (mem_addr_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/tb_stmem_ctrl.sv
`timescale 1ns/1ps
module tb_stmem_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_strb = '0;
  logic        req_ready, rd_valid;
  logic [31:0] rd_data;
  logic [3:0]  cfg_w16 = 4'b1101;
  // per bank {turn,wait,delay}: bank3..bank0
  logic [47:0] rd_tim = {12'h111, 12'h013, 12'h000, 12'h132};
  logic [47:0] wr_tim = {12'h322, 12'h251, 12'h111, 12'h110};
  logic [3:0]  cs_n;
  logic        oe_n, we_n, dq_oe;
  logic [1:0]  be_n;
  logic [19:0] maddr;
  logic [15:0] dq_o, dq_i;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  stmem_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_burst_i(req_burst), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_strb_i(req_strb), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .cfg_w16_i(cfg_w16), .rd_tim_i(rd_tim), .wr_tim_i(wr_tim),
    .mem_cs_no(cs_n), .mem_oe_no(oe_n), .mem_we_no(we_n), .mem_be_no(be_n),
    .mem_addr_o(maddr), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  // memory model: 64 bytes per bank
  logic [7:0] m [4][64];
  function automatic logic [7:0] init_byte(int b, int i);
    return 8'((b * 64 + i) ^ 8'h5A);
  endfunction

  function automatic int cs_bank(logic [3:0] c);
    for (int b = 0; b < 4; b++) if (!c[b]) return b;
    return -1;
  endfunction

  always_comb begin
    int b;
    b = cs_bank(cs_n);
    dq_i = '0;
    if (b >= 0) begin
      if (cfg_w16[b]) dq_i = {m[b][{maddr[4:0], 1'b1}], m[b][{maddr[4:0], 1'b0}]};
      else            dq_i = {8'h00, m[b][maddr[5:0]]};
    end
  end

  // event monitor
  int          ev_n, pre, width, gap, cs_starts;
  int          ev_setup [32], ev_width [32], gap_log [32];
  logic [19:0] ev_addr [32];
  logic [1:0]  ev_be [32];
  logic        ev_wr [32];
  logic [3:0]  ev_cs [32];
  logic [15:0] ev_dq [32];
  logic        prev_strobe, prev_cs;

  always @(negedge clk) begin
    int b;
    logic strobe, cs_act;
    if (!rst_n) begin
      for (int bb = 0; bb < 4; bb++)
        for (int i = 0; i < 64; i++) m[bb][i] = init_byte(bb, i);
      ev_n = 0; pre = 0; width = 0; gap = 0; cs_starts = 0;
      prev_strobe = 1'b0; prev_cs = 1'b0;
    end else begin
      strobe = !oe_n || !we_n;
      cs_act = (cs_n != 4'hF);
      if (!we_n) begin
        b = cs_bank(cs_n);
        if (b >= 0) begin
          if (cfg_w16[b]) begin
            if (!be_n[0]) m[b][{maddr[4:0], 1'b0}] = dq_o[7:0];
            if (!be_n[1]) m[b][{maddr[4:0], 1'b1}] = dq_o[15:8];
          end else if (!be_n[0]) m[b][maddr[5:0]] = dq_o[7:0];
        end
      end
      if (cs_act && !prev_cs && cs_starts < 32) begin
        gap_log[cs_starts] = gap;
        cs_starts++;
      end
      if (!cs_act) begin gap++; pre = 0; end else gap = 0;
      if (strobe && !prev_strobe && ev_n < 32) begin
        ev_setup[ev_n] = pre; ev_addr[ev_n] = maddr; ev_be[ev_n] = be_n;
        ev_wr[ev_n] = !we_n; ev_cs[ev_n] = cs_n; ev_dq[ev_n] = dq_o;
        width = 1; pre = 0;
      end else if (strobe) width++;
      else if (cs_act) pre++;
      if (!strobe && prev_strobe && ev_n < 32) begin
        ev_width[ev_n] = width;
        ev_n++;
      end
      prev_strobe = strobe;
      prev_cs = cs_act;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_ev();
    @(negedge clk); #1;
    ev_n = 0; cs_starts = 0;
  endtask

  task automatic send(input logic wr, input logic bst, input logic [31:0] a,
                      input logic [31:0] d, input logic [3:0] s, output int waits);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_burst = bst;
    req_addr = a; req_wdata = d; req_strb = s;
    waits = 0;
    #1;
    while (!req_ready && waits < 2000) begin
      @(negedge clk); #1; waits++;
    end
    @(negedge clk);
    req_valid = 1'b0; req_burst = 1'b0;
    #1;
  endtask

  task automatic get_rd(output logic [31:0] d);
    int n = 0;
    while (!rd_valid && n < 2000) begin @(negedge clk); #1; n++; end
    d = rd_data;
    @(negedge clk); #1;
    chk("R11 rd_valid one cycle", 32'(rd_valid), 32'd0);
  endtask

  task automatic quiet();
    int q = 0;
    while (q < 10) begin
      @(negedge clk); #1;
      if (cs_n == 4'hF && we_n && oe_n) q++; else q = 0;
    end
  endtask

  function automatic logic [31:0] word_at(int b, int off);
    return {m[b][off+3], m[b][off+2], m[b][off+1], m[b][off]};
  endfunction

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R12 cs idle", 32'(cs_n), 32'hF);
    chk("R12 oe/we", {30'd0, oe_n, we_n}, 32'd3);
    chk("R12 rd_valid", 32'(rd_valid), 32'd0);
    chk("R12 ready", 32'(req_ready), 32'd1);
  endtask

  task automatic t_read16();
    int w; logic [31:0] d, e;
    e = word_at(0, 8);
    clear_ev();
    send(1'b0, 1'b0, 32'h0000_0008, '0, 4'h0, w);
    get_rd(d); quiet();
    chk("R11 R6 read16 data", d, e);
    chk("R6 read16 count", ev_n, 2);
    chk("R6 read16 addr0", 32'(ev_addr[0]), 32'd4);
    chk("R6 read16 addr1", 32'(ev_addr[1]), 32'd5);
    chk("R2 read16 setup", ev_setup[0], 3);
    chk("R2 read16 setup sub1", ev_setup[1], 3);
    chk("R3 read16 oe width", ev_width[0], 4);
    chk("R1 read16 cs", 32'(ev_cs[0]), 32'hE);
    chk("R7 read be", 32'(ev_be[0]), 32'd0);
  endtask

  task automatic t_read8();
    int w; logic [31:0] d, e;
    e = word_at(1, 4);
    clear_ev();
    send(1'b0, 1'b0, 32'h0400_0004, '0, 4'h0, w);
    get_rd(d); quiet();
    chk("R6 read8 data", d, e);
    chk("R6 read8 count", ev_n, 4);
    chk("R6 read8 addr3", 32'(ev_addr[3]), 32'd7);
    chk("R1 read8 cs", 32'(ev_cs[2]), 32'hD);
    chk("R2 read8 setup", ev_setup[1], 1);
    chk("R3 read8 width", ev_width[3], 1);
  endtask

  task automatic t_write_timing();
    int w; logic [31:0] d;
    clear_ev();
    send(1'b1, 1'b0, 32'h0800_0004, 32'hDEAD_BEEF, 4'hF, w);
    quiet();
    chk("R7 write16 count", ev_n, 2);
    chk("R4 R2 write setup", ev_setup[0], 2);
    chk("R4 R3 write width", ev_width[1], 6);
    chk("R7 write be", 32'(ev_be[0]), 32'd0);
    chk("R6 write lo half", 32'(ev_dq[0]), 32'h0000_BEEF);
    chk("R6 write hi half addr", 32'(ev_addr[1]), 32'd3);
    chk("R6 write mem", word_at(2, 4), 32'hDEAD_BEEF);
    clear_ev();
    send(1'b0, 1'b0, 32'h0800_0004, '0, 4'h0, w);
    get_rd(d); quiet();
    chk("R4 readback data", d, 32'hDEAD_BEEF);
    chk("R4 read setup", ev_setup[0], 4);
    chk("R4 read width", ev_width[0], 2);
  endtask

  task automatic t_partial();
    int w; logic [7:0] keep0, keep2;
    keep0 = m[0][32];
    keep2 = m[0][34];
    clear_ev();
    send(1'b1, 1'b0, 32'h0000_0020, 32'hA1B2_C3D4, 4'b0010, w);
    quiet();
    chk("R7 partial16 pulses", ev_n, 1);
    chk("R7 partial16 be", 32'(ev_be[0]), 32'd1);
    chk("R7 partial16 byte1", 32'(m[0][33]), 32'hC3);
    chk("R7 partial16 byte0 kept", 32'(m[0][32]), 32'(keep0));
    chk("R7 partial16 byte2 kept", 32'(m[0][34]), 32'(keep2));
    clear_ev();
    send(1'b1, 1'b0, 32'h0400_0008, 32'hA1B2_C3D4, 4'b0100, w);
    quiet();
    chk("R7 partial8 pulses", ev_n, 1);
    chk("R7 partial8 addr", 32'(ev_addr[0]), 32'd10);
    chk("R7 partial8 be", 32'(ev_be[0]), 32'd2);
    chk("R7 partial8 byte", 32'(m[1][10]), 32'hB2);
  endtask

  task automatic t_burst();
    int w0, w1, w2, wr; logic [31:0] d;
    clear_ev();
    send(1'b1, 1'b0, 32'h0C00_0010, 32'h1122_3344, 4'hF, w0);
    send(1'b1, 1'b1, 32'h0C00_03FC, 32'h5566_7788, 4'hF, w1);
    chk("R8 beat1 no wait", w1, 0);
    chk("R8 posted before write pulse", {31'd0, we_n}, 32'd1);
    chk("R8 no write done yet", ev_n, 0);
    send(1'b1, 1'b1, 32'h0C00_0000, 32'h9900_AABB, 4'hF, w2);
    chk("R10 full buffer stalls", 32'(w2 > 0), 32'd1);
    send(1'b0, 1'b0, 32'h0C00_0014, '0, 4'h0, wr);
    chk("R10 read waits for drain", 32'(wr > 0), 32'd1);
    chk("R10 read after all writes", ev_n, 6);
    get_rd(d); quiet();
    chk("R9 beat1 address", word_at(3, 20), 32'h5566_7788);
    chk("R9 beat2 address", word_at(3, 24), 32'h9900_AABB);
    chk("R6 beat0 data", word_at(3, 16), 32'h1122_3344);
    chk("R9 beat1 ext addr", 32'(ev_addr[2]), 32'd10);
    chk("R5 gap word0-1", gap_log[1], 4);
    chk("R5 gap word1-2", gap_log[2], 4);
    chk("R10 read data drained", d, 32'h5566_7788);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired req=all");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk("R12 cs in reset", 32'(cs_n), 32'hF);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read16();
    t_read8();
    t_write_timing();
    t_partial();
    t_burst();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule